// File: doc/BRIEF.md
# Outbound Doorbell Completion Tracker

This block follows outbound doorbell requests from acceptance to completion. A requester hands over a descriptor of `INFO_W` bits. The block parks it in one of `NSLOT` tracking slots and offers it on a valid/ready transmit port, tagged with the slot index. Responses come back carrying that tag and a kind: done, error or retry.

A retry puts the descriptor back in the send queue, and the number of retries has no limit. Done and error responses finish the request. A request that gets no answer before its deadline also finishes, with a timeout status. The deadline is a programmable interval added to a free-running wrapping counter.

Each finished request lands in a completion FIFO as a status code and the original descriptor. Software drains the FIFO through a small register port. A sticky completion flag, optionally routed to an interrupt, tells software that entries are waiting. The flag drops by itself once the FIFO has drained.

Top module: `dbell_cpl_tracker`

## Requirements
- R1: After reset, `req_ready`=1, `tx_valid`=0 and `irq`=0, and the occupancy, flag and pop registers read 0.
- R2: An accepted request goes to the lowest-numbered free slot. It appears on the transmit port with its descriptor in `tx_info` and the slot index in `tx_tag`.
- R3: Reading address 0 returns the oldest completion as {status[17:16], descriptor[INFO_W-1:0]} and removes it. Status 2'b00 means done, 2'b01 means error and 2'b10 means timeout. Completions are returned in the order they finished. A read with the FIFO empty returns 0.
- R4: A response of kind 2'b10 (retry) sends the same descriptor again under the same tag and creates no completion. This repeats for any number of retries.
- R5: A sent request with no response completes with status 2'b10, about `tmo` cycles after it was sent and not earlier. This holds when the counter wraps.
- R6: A response whose tag names a slot that is not waiting for a response is ignored.
- R7: `req_ready` is 0 whenever the FIFO count plus the outstanding requests reaches `DEPTH`, so nothing is accepted while the FIFO is full.
- R8: The flag (address 2, bit 0) is set by every completion. It clears itself the cycle after the FIFO is found empty. Writing 1 to bit 0 also clears it.
- R9: `irq` is high only while the flag is set and the enable bit (address 3, bit 0, read/write) is 1. In the default registered variant, `irq` follows one cycle later.
- R10: Address 1 reads the number of entries in the completion FIFO.
- R11: Address 4 holds the timeout interval (`CNT_W` bits, read/write). Response kind 2'b00 means done; any kind other than 2'b00 or 2'b10 means error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request descriptor offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_info | input | INFO_W | Request descriptor |
| tx_valid | output | 1 | Doorbell ready to send |
| tx_ready | input | 1 | Transmit side takes the doorbell |
| tx_tag | output | TAG_W | Slot index of the doorbell |
| tx_info | output | INFO_W | Descriptor being sent |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | TAG_W | Slot the response belongs to |
| rsp_kind | input | 2 | 00 done, 10 retry, others error |
| csr_sel | input | 1 | Register access strobe |
| csr_wr | input | 1 | 1 write, 0 read |
| csr_addr | input | 3 | Register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach is a timeout that falls across a counter wrap, because the default counter is 24 bits wide. The bench builds the block with a 10-bit counter. It runs four back-to-back timeout rounds of 300 cycles, so at least one deadline straddles the wrap. A second hard case is admission at the FIFO limit. Seven queued completions plus one outstanding request must already close `req_ready`. The bench fills the FIFO one error completion at a time and holds a request against the closed port.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
   localparam logic [1:0] RSP_DONE  = 2'b00;
   localparam logic [1:0] RSP_RETRY = 2'b10;
   localparam logic [1:0] CPL_DONE  = 2'b00;
   localparam logic [1:0] CPL_ERR   = 2'b01;
   localparam logic [1:0] CPL_TMO   = 2'b10;
   localparam logic [2:0] A_POP = 3'd0;
   localparam logic [2:0] A_CNT = 3'd1;
   localparam logic [2:0] A_STS = 3'd2;
   localparam logic [2:0] A_EN  = 3'd3;
   localparam logic [2:0] A_TMO = 3'd4;
endpackage

// File: rtl/dbt_slots.sv
module dbt_slots #(
   parameter int NSLOT  = 2,
   parameter int INFO_W = 16,
   parameter int CNT_W  = 24,
   parameter int TAG_W  = 1,
   parameter int BW     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [INFO_W-1:0] acc_info,
   output logic              have_free,
   output logic [BW-1:0]     busy_cnt,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [TAG_W-1:0]  tx_tag,
   output logic [INFO_W-1:0] tx_info,
   input  logic              rsp_valid,
   input  logic [TAG_W-1:0]  rsp_tag,
   input  logic [1:0]        rsp_kind,
   input  logic [CNT_W-1:0]  now,
   input  logic [CNT_W-1:0]  tmo,
   output logic              cpl_valid,
   output logic [1:0]        cpl_status,
   output logic [INFO_W-1:0] cpl_info
);
   import dbt_pkg::*;

   logic [NSLOT-1:0]  busy, pend, waiting, expired, exp_m;
   logic [INFO_W-1:0] info_q [NSLOT];
   logic [CNT_W-1:0]  dl_q   [NSLOT];
   logic [TAG_W-1:0]  free_idx, pend_idx, exp_idx, cpl_tag;
   logic              any_pend, any_exp, rsp_hit, rsp_fin, rsp_retry;

   assign waiting = busy & ~pend;

   genvar g;
   generate
      for (g = 0; g < NSLOT; g++) begin : g_slot
         logic [CNT_W-1:0] gap;
         assign gap        = now - dl_q[g];
         assign expired[g] = waiting[g] & ~gap[CNT_W-1];
      end
   endgenerate

   assign rsp_hit   = rsp_valid && waiting[rsp_tag];
   assign rsp_retry = rsp_hit && (rsp_kind == RSP_RETRY);
   assign rsp_fin   = rsp_hit && (rsp_kind != RSP_RETRY);

   always_comb begin
      exp_m = expired;
      if (rsp_hit) exp_m[rsp_tag] = 1'b0;
   end

   always_comb begin
      have_free = 1'b0; free_idx = '0;
      any_pend  = 1'b0; pend_idx = '0;
      any_exp   = 1'b0; exp_idx  = '0;
      busy_cnt  = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (!busy[i]) begin have_free = 1'b1; free_idx = TAG_W'(i); end
         if (pend[i])  begin any_pend  = 1'b1; pend_idx = TAG_W'(i); end
         if (exp_m[i]) begin any_exp   = 1'b1; exp_idx  = TAG_W'(i); end
      end
      for (int i = 0; i < NSLOT; i++) busy_cnt = busy_cnt + BW'(busy[i]);
   end

   assign tx_valid = any_pend;
   assign tx_tag   = pend_idx;
   assign tx_info  = info_q[pend_idx];

   always_comb begin
      cpl_valid  = 1'b0;
      cpl_tag    = '0;
      cpl_status = CPL_DONE;
      if (rsp_fin) begin
         cpl_valid  = 1'b1;
         cpl_tag    = rsp_tag;
         cpl_status = (rsp_kind == RSP_DONE) ? CPL_DONE : CPL_ERR;
      end else if (any_exp) begin
         cpl_valid  = 1'b1;
         cpl_tag    = exp_idx;
         cpl_status = CPL_TMO;
      end
   end
   assign cpl_info = info_q[cpl_tag];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= '0;
         pend <= '0;
         for (int i = 0; i < NSLOT; i++) begin
            info_q[i] <= '0;
            dl_q[i]   <= '0;
         end
      end else begin
         for (int i = 0; i < NSLOT; i++) begin
            if (acc_valid && have_free && free_idx == TAG_W'(i)) begin
               busy[i]   <= 1'b1;
               pend[i]   <= 1'b1;
               info_q[i] <= acc_info;
            end
            if (tx_valid && tx_ready && tx_tag == TAG_W'(i)) begin
               pend[i] <= 1'b0;
               dl_q[i] <= now + tmo;
            end
            if (rsp_retry && rsp_tag == TAG_W'(i)) begin
               pend[i] <= 1'b1;
               dl_q[i] <= now + tmo;
            end
            if (cpl_valid && cpl_tag == TAG_W'(i)) busy[i] <= 1'b0;
         end
      end
   end

   // R6: only a slot that was tracking a request can complete
   a_r6_cpl_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> busy[cpl_tag]);
   // R4: a retry always puts a doorbell back on the transmit port
   a_r4_retry_resends: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_retry |=> tx_valid);
   // R4: a retry never finishes the slot it names
   a_r4_retry_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_retry |=> busy[$past(rsp_tag)]);
endmodule

// File: rtl/dbt_cfifo.sv
module dbt_cfifo #(
   parameter int DEPTH = 8,
   parameter int W     = 18,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_p, wr_p;

   assign head = mem[rd_p];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_p  <= '0;
         wr_p  <= '0;
         count <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (push) begin
            mem[wr_p] <= push_data;
            wr_p      <= wr_p + 1'b1;
         end
         if (pop) rd_p <= rd_p + 1'b1;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   // R7: admission control must keep the FIFO from overflowing
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CW'(DEPTH)) || pop);
   // R3: entries are only removed when present
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
endmodule

// File: rtl/dbt_regs.sv
module dbt_regs #(
   parameter int              INFO_W  = 16,
   parameter int              CNT_W   = 24,
   parameter int              CW      = 4,
   parameter bit              IRQ_REG = 1'b1,
   parameter logic [CNT_W-1:0] TMO_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_sel,
   input  logic              csr_wr,
   input  logic [2:0]        csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic [INFO_W+1:0] fifo_head,
   input  logic [CW-1:0]     fifo_cnt,
   input  logic              fifo_push,
   output logic              fifo_pop,
   output logic [CNT_W-1:0]  tmo,
   output logic              irq
);
   import dbt_pkg::*;

   logic en_q, flag_q;
   logic fifo_empty, wr_acc, rd_acc;

   assign fifo_empty = (fifo_cnt == '0);
   assign wr_acc     = csr_sel && csr_wr;
   assign rd_acc     = csr_sel && !csr_wr;
   assign fifo_pop   = rd_acc && (csr_addr == A_POP) && !fifo_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         flag_q <= 1'b0;
         tmo    <= TMO_RST;
      end else begin
         if (wr_acc && csr_addr == A_EN)  en_q <= csr_wdata[0];
         if (wr_acc && csr_addr == A_TMO) tmo  <= csr_wdata[CNT_W-1:0];
         if (fifo_push)                                     flag_q <= 1'b1;
         else if (fifo_empty)                               flag_q <= 1'b0;
         else if (wr_acc && csr_addr == A_STS && csr_wdata[0]) flag_q <= 1'b0;
      end
   end

   always_comb begin
      csr_rdata = '0;
      if (rd_acc) begin
         case (csr_addr)
            A_POP: if (!fifo_empty) csr_rdata[INFO_W+1:0] = fifo_head;
            A_CNT: csr_rdata[CW-1:0]    = fifo_cnt;
            A_STS: csr_rdata[0]         = flag_q;
            A_EN:  csr_rdata[0]         = en_q;
            A_TMO: csr_rdata[CNT_W-1:0] = tmo;
            default: csr_rdata = '0;
         endcase
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag_q && en_q;
         end
         assign irq = irq_q;
         // R9: a registered interrupt needs the enable one cycle earlier
         a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en_q) |-> !irq);
      end else begin : g_irq_comb
         assign irq = flag_q && en_q;
         // R9: no interrupt without the enable
         a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q |-> !irq);
      end
   endgenerate

   // R8: an empty FIFO with nothing arriving drops the flag
   a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && !fifo_push) |=> !flag_q);
   // R8: every completion raises the flag
   a_r8_set_on_cpl: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |=> flag_q);
endmodule

// File: rtl/dbell_cpl_tracker.sv
module dbell_cpl_tracker #(
   parameter int               NSLOT   = 2,
   parameter int               DEPTH   = 8,
   parameter int               INFO_W  = 16,
   parameter int               CNT_W   = 24,
   parameter bit               IRQ_REG = 1'b1,
   parameter logic [CNT_W-1:0] TMO_RST = CNT_W'(200),
   parameter int               TAG_W   = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [INFO_W-1:0] req_info,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [TAG_W-1:0]  tx_tag,
   output logic [INFO_W-1:0] tx_info,
   input  logic              rsp_valid,
   input  logic [TAG_W-1:0]  rsp_tag,
   input  logic [1:0]        rsp_kind,
   input  logic              csr_sel,
   input  logic              csr_wr,
   input  logic [2:0]        csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output logic              irq
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int BW = $clog2(NSLOT + 1);
   localparam int EW = INFO_W + 2;

   generate
      if (NSLOT < 2 || (NSLOT & (NSLOT - 1)) != 0)
         $error("NSLOT must be a power of two, at least 2");
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("DEPTH must be a power of two, at least 2");
      if (NSLOT > DEPTH)
         $error("NSLOT may not exceed DEPTH");
      if (EW > 32 || CNT_W > 32 || CNT_W < 4)
         $error("INFO_W+2 and CNT_W must fit the 32-bit register port");
      if (TAG_W != $clog2(NSLOT))
         $error("TAG_W must match NSLOT");
   endgenerate

   logic [CNT_W-1:0]  now_q;
   logic [CNT_W-1:0]  tmo;
   logic              have_free, acc;
   logic [BW-1:0]     busy_cnt;
   logic              cpl_valid;
   logic [1:0]        cpl_status;
   logic [INFO_W-1:0] cpl_info;
   logic [EW-1:0]     fifo_head;
   logic [CW-1:0]     fifo_cnt;
   logic              fifo_pop;

   always_ff @(posedge clk) begin
      if (!rst_n) now_q <= '0;
      else        now_q <= now_q + 1'b1;
   end

   assign req_ready = have_free && ((int'(fifo_cnt) + int'(busy_cnt)) < DEPTH);
   assign acc       = req_valid && req_ready;

   dbt_slots #(
      .NSLOT(NSLOT), .INFO_W(INFO_W), .CNT_W(CNT_W), .TAG_W(TAG_W), .BW(BW)
   ) slots_i (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc), .acc_info(req_info),
      .have_free(have_free), .busy_cnt(busy_cnt),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_tag(tx_tag), .tx_info(tx_info),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_kind(rsp_kind),
      .now(now_q), .tmo(tmo),
      .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_info(cpl_info)
   );

   dbt_cfifo #(.DEPTH(DEPTH), .W(EW), .CW(CW)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push(cpl_valid), .push_data({cpl_status, cpl_info}),
      .pop(fifo_pop), .head(fifo_head), .count(fifo_cnt)
   );

   dbt_regs #(
      .INFO_W(INFO_W), .CNT_W(CNT_W), .CW(CW), .IRQ_REG(IRQ_REG), .TMO_RST(TMO_RST)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .csr_sel(csr_sel), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .fifo_head(fifo_head), .fifo_cnt(fifo_cnt), .fifo_push(cpl_valid),
      .fifo_pop(fifo_pop), .tmo(tmo), .irq(irq)
   );

   // R7: a full FIFO closes the request port
   a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_cnt == CW'(DEPTH)) |-> !req_ready);
   // R2: an accepted request is offered for transmit on the next cycle
   a_r2_accept_sends: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> tx_valid);
endmodule

// File: tb/dbell_cpl_tracker_tb.sv
module dbell_cpl_tracker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int INFO_W = 16;
   localparam int CNT_W  = 10;
   localparam int DEPTH  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_ready;
   logic [INFO_W-1:0] req_info = '0;
   logic              tx_valid, tx_ready = 1'b1;
   logic [0:0]        tx_tag;
   logic [INFO_W-1:0] tx_info;
   logic              rsp_valid = 1'b0;
   logic [0:0]        rsp_tag = '0;
   logic [1:0]        rsp_kind = '0;
   logic              csr_sel = 1'b0, csr_wr = 1'b0;
   logic [2:0]        csr_addr = '0;
   logic [31:0]       csr_wdata = '0, csr_rdata;
   logic              irq;

   int n_chk = 0, n_fail = 0, sends = 0;
   bit finished = 1'b0;
   logic [0:0]        last_tag;
   logic [INFO_W-1:0] last_info;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbell_cpl_tracker #(.NSLOT(2), .DEPTH(DEPTH), .INFO_W(INFO_W), .CNT_W(CNT_W),
                       .IRQ_REG(1'b1), .TMO_RST(10'd200)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_info(req_info), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_tag(tx_tag), .tx_info(tx_info), .rsp_valid(rsp_valid),
      .rsp_tag(rsp_tag), .rsp_kind(rsp_kind), .csr_sel(csr_sel),
      .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .irq(irq));

   always @(posedge clk) begin
      if (tx_valid && tx_ready) begin
         sends     <= sends + 1;
         last_tag  <= tx_tag;
         last_info <= tx_info;
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(input logic [INFO_W-1:0] info);
      @(negedge clk); req_valid = 1'b1; req_info = info;
      @(negedge clk); req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic respond(input logic [0:0] tag, input logic [1:0] kind);
      @(negedge clk); rsp_valid = 1'b1; rsp_tag = tag; rsp_kind = kind;
      @(negedge clk); rsp_valid = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); csr_sel = 1'b1; csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk); csr_sel = 1'b0; csr_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); csr_sel = 1'b1; csr_wr = 1'b0; csr_addr = a;
      #1 d = csr_rdata;
      @(negedge clk); csr_sel = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 req_ready", 32'(req_ready), 1);
      chk("R1 tx_valid", 32'(tx_valid), 0);
      chk("R1 irq", 32'(irq), 0);
      rd(3'd1, d); chk("R1 count", d, 0);
      rd(3'd2, d); chk("R1 flag", d, 0);
      rd(3'd0, d); chk("R3 empty pop", d, 0);
      rd(3'd4, d); chk("R11 tmo reset", d, 200);
   endtask

   task automatic t_done;
      logic [31:0] d;
      issue(16'hA5A5);
      chk("R2 info", 32'(last_info), 32'hA5A5);
      chk("R2 tag", 32'(last_tag), 0);
      respond(1'b0, 2'b00);
      rd(3'd1, d); chk("R10 count 1", d, 1);
      rd(3'd2, d); chk("R8 flag set", d, 1);
      chk("R9 irq disabled", 32'(irq), 0);
      rd(3'd0, d); chk("R3 done entry", d, 32'h0000A5A5);
      rd(3'd1, d); chk("R10 count 0", d, 0);
      rd(3'd2, d); chk("R8 self clear", d, 0);
   endtask

   task automatic t_two;
      logic [31:0] d;
      issue(16'h1111);
      issue(16'h2222);
      chk("R2 second tag", 32'(last_tag), 1);
      respond(1'b1, 2'b01);
      respond(1'b0, 2'b00);
      rd(3'd0, d); chk("R3 first finished", d, 32'h00012222);
      rd(3'd0, d); chk("R3 second finished", d, 32'h00001111);
   endtask

   task automatic t_retry;
      logic [31:0] d;
      int s0;
      issue(16'h3333);
      for (int k = 0; k < 3; k++) begin
         s0 = sends;
         respond(1'b0, 2'b10);
         cyc(1);
         chk("R4 resend count", 32'(sends), 32'(s0 + 1));
         chk("R4 resend info", 32'(last_info), 32'h3333);
         chk("R4 resend tag", 32'(last_tag), 0);
      end
      rd(3'd1, d); chk("R4 no completion", d, 0);
      respond(1'b0, 2'b11);
      rd(3'd0, d); chk("R11 kind 11 is error", d, 32'h00013333);
   endtask

   task automatic t_ignore;
      logic [31:0] d;
      respond(1'b1, 2'b00);
      rd(3'd1, d); chk("R6 idle tag", d, 0);
      issue(16'h5555);
      respond(1'b1, 2'b01);
      rd(3'd1, d); chk("R6 other tag", d, 0);
      respond(1'b0, 2'b00);
      rd(3'd0, d); chk("R6 real response", d, 32'h00005555);
   endtask

   task automatic t_timeout;
      logic [31:0] d;
      wr(3'd4, 32'd300);
      rd(3'd4, d); chk("R11 tmo readback", d, 300);
      for (int k = 0; k < 4; k++) begin
         issue(16'h4000 + 16'(k));
         cyc(285);
         rd(3'd1, d); chk("R5 not early", d, 0);
         cyc(20);
         rd(3'd1, d); chk("R5 timed out", d, 1);
         rd(3'd0, d); chk("R5 timeout status", d, 32'h00024000 + 32'(k));
      end
      wr(3'd4, 32'd200);
   endtask

   task automatic t_irq;
      logic [31:0] d;
      wr(3'd3, 32'd1);
      rd(3'd3, d); chk("R9 enable readback", d, 1);
      issue(16'h6001);
      respond(1'b0, 2'b01);
      cyc(2);
      chk("R9 irq high", 32'(irq), 1);
      issue(16'h6002);
      respond(1'b0, 2'b00);
      wr(3'd2, 32'd1);
      cyc(2);
      rd(3'd2, d); chk("R8 write one clears", d, 0);
      chk("R9 irq follows flag", 32'(irq), 0);
      rd(3'd1, d); chk("R8 entries kept", d, 2);
      rd(3'd0, d); chk("R3 pop a", d, 32'h00016001);
      rd(3'd0, d); chk("R3 pop b", d, 32'h00006002);
      wr(3'd3, 32'd0);
   endtask

   task automatic t_full;
      logic [31:0] d;
      int s0;
      for (int k = 0; k < DEPTH; k++) begin
         issue(16'h7000 + 16'(k));
         if (k == DEPTH - 1) chk("R7 reserve closes", 32'(req_ready), 0);
         respond(1'b0, 2'b01);
      end
      rd(3'd1, d); chk("R10 full count", d, DEPTH);
      chk("R7 full ready", 32'(req_ready), 0);
      s0 = sends;
      @(negedge clk); req_valid = 1'b1; req_info = 16'hBEEF;
      cyc(5);
      req_valid = 1'b0;
      cyc(2);
      chk("R7 nothing sent", 32'(sends), 32'(s0));
      for (int k = 0; k < DEPTH; k++) begin
         rd(3'd0, d); chk("R3 fifo order", d, 32'h00017000 + 32'(k));
      end
      chk("R7 reopens", 32'(req_ready), 1);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_done();
      t_two();
      t_retry();
      t_ignore();
      t_timeout();
      t_irq();
      t_full();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hang expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule